// File: doc/BRIEF.md
# Seven-to-One Camera Link Pixel Serializer

This block turns one parallel video word per pixel period into four serial data lanes and a forwarded clock lane. Everything runs from a single bit clock at seven times the pixel rate. A free-running slot counter divides each pixel period into seven bit slots. The block asks for a new pixel once per period with `take_o`, and it samples its parallel inputs at the clock edge that ends that cycle.

Before serialization, a format stage places the pixel value onto the 24-bit colour field. The field is R in bits 7..0, G in bits 15..8 and B in bits 23..16. The format stage can pass RGB through unchanged. It can also place a 14-bit or 8-bit grayscale sample, or a 16-bit value, onto the G and R channels. The three frame-timing flags travel with every word, and the spare bit is always sent as zero. The analog line drivers and the generation of the bit clock are handled outside this block.

Top module: `clink_serializer`

## Requirements
- R1: While `rst_n` is low, all four data lanes are 0, the clock lane is 1 and `take_o` is 0.
- R2: `take_o` is high for exactly one bit-clock cycle in every seven. The inputs are captured at the rising edge that ends that cycle. That cycle falls in the clock lane's high phase.
- R3: Slot 0 is the first bit-clock cycle after a capture edge. The clock lane is high during slots 5, 6, 0 and 1 and low during slots 2, 3 and 4. This gives 4 high cycles and 3 low cycles per pixel, with the rise at slot 5.
- R4: Each lane sends its seven bits b6..b0 in slots 0..6, so a pixel starts in the middle of the clock's high phase. Counted from a clock rise, a lane shows b1, b0 (previous pixel), then b6, b5, b4, b3, b2.
- R5: The 28-bit word is {spare, DVAL, FVAL, LVAL, B[7:0], G[7:0], R[7:0]}, from bit 27 down to bit 0. Bit bj of lane k is word bit 7k+j.
- R6: Format 0 (RGB): R = pix[7:0], G = pix[15:8], B = pix[23:16].
- R7: Format 1 (14-bit gray): G[5:0] = pix[13:8] and R[7:0] = pix[7:0].
- R8: Format 2 (8-bit gray): G[5:0] = pix[7:2] and R[7:6] = pix[1:0].
- R9: Format 3 (16-bit): G[7:0] = pix[15:8] and R[7:0] = pix[7:0].
- R10: Any port bit that the selected format does not fill is sent as 0, and so is the spare bit. Input bits outside the format's field have no effect on the lanes.
- R11: `lval_i`, `fval_i` and `dval_i` reach their word bits unchanged in every format.
- R12: Pixels follow each other without idle slots. A format change applies from the next captured pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i | input | 2 | Format select: 0 RGB, 1 gray14, 2 gray8, 3 16-bit |
| pix_i | input | 24 | Pixel value |
| lval_i | input | 1 | Line-valid flag |
| fval_i | input | 1 | Frame-valid flag |
| dval_i | input | 1 | Data-valid flag |
| take_o | output | 1 | High in the cycle whose closing edge captures the inputs |
| clk_lane_o | output | 1 | Forwarded clock lane (4 high, 3 low) |
| data_lane_o | output | 4 | Serial data lanes 3..0 |

## Verification
The checker watches the pixel-period timing on every cycle. It checks the seven-cycle spacing of `take_o`, the four-high and three-low run lengths of the clock lane, and the placement of `take_o` inside the high phase. It also checks that every lane's first bit after a capture equals bit b6 of the word just mapped, and that the spare lane bit is zero. What only the bench's scenarios can show is whether the mapped word is correct. This covers each format's placement of pixel bits, the zeroing of bits each format ignores, the passage of the flags, and the full b6..b0 order of each lane across back-to-back pixels with changing formats.

// File: rtl/clser_pkg.sv
package clser_pkg;

  localparam int unsigned CL_SLOTS  = 7;   // bit slots per pixel period
  localparam int unsigned CL_LANES  = 4;   // serial data lanes
  localparam int unsigned CL_CHAN_W = 8;   // bits per colour channel
  localparam int unsigned CL_HIGH   = 4;   // clock-lane high slots
  localparam int unsigned CL_PIX_W  = 3 * CL_CHAN_W;
  localparam int unsigned CL_WORD_W = CL_SLOTS * CL_LANES;

  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_GRAY14 = 2'd1,
    FMT_GRAY8  = 2'd2,
    FMT_WIDE16 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                 spare;
    logic                 dval;
    logic                 fval;
    logic                 lval;
    logic [CL_CHAN_W-1:0] blu;
    logic [CL_CHAN_W-1:0] grn;
    logic [CL_CHAN_W-1:0] red;
  } cl_word_t;

  // Place a pixel value onto the colour field for the chosen format.
  function automatic logic [CL_PIX_W-1:0] place_pixel(input fmt_e fmt,
                                                      input logic [CL_PIX_W-1:0] pix);
    logic [CL_CHAN_W-1:0] r, g, b;
    r = '0;
    g = '0;
    b = '0;
    unique case (fmt)
      FMT_RGB: begin
        r = pix[7:0];
        g = pix[15:8];
        b = pix[23:16];
      end
      FMT_GRAY14: begin
        r      = pix[7:0];
        g[5:0] = pix[13:8];
      end
      FMT_GRAY8: begin
        r[7:6] = pix[1:0];
        g[5:0] = pix[7:2];
      end
      FMT_WIDE16: begin
        r = pix[7:0];
        g = pix[15:8];
      end
      default: ;
    endcase
    return {b, g, r};
  endfunction

endpackage

// File: rtl/clser_phase.sv
module clser_phase #(
  parameter int unsigned SLOTS      = clser_pkg::CL_SLOTS,
  parameter int unsigned HIGH_SLOTS = clser_pkg::CL_HIGH,
  localparam int unsigned PW        = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] slot_o,
  output logic          load_o,
  output logic          clk_lane_o
);

  localparam int unsigned HALF     = HIGH_SLOTS / 2;
  localparam logic [PW-1:0] LAST   = PW'(SLOTS - 1);
  localparam logic [PW-1:0] START  = PW'(SLOTS - HALF);

  // Clock level for a slot: high across the pixel boundary, centred on it.
  function automatic logic level_of(input logic [PW-1:0] s);
    return (32'(s) < HALF) || (32'(s) >= SLOTS - HALF);
  endfunction

  logic [PW-1:0] slot_q, slot_nxt;
  logic          clk_q;

  always_comb slot_nxt = (slot_q == LAST) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= START;
      clk_q  <= level_of(START);
    end else begin
      slot_q <= slot_nxt;
      clk_q  <= level_of(slot_nxt);
    end
  end

  assign slot_o     = slot_q;
  assign load_o     = (slot_q == LAST);
  assign clk_lane_o = clk_q;

endmodule

// File: rtl/clser_mapper.sv
module clser_mapper
  import clser_pkg::*;
(
  input  fmt_e                  fmt_i,
  input  logic [CL_PIX_W-1:0]   pix_i,
  input  logic                  lval_i,
  input  logic                  fval_i,
  input  logic                  dval_i,
  output logic [CL_WORD_W-1:0]  word_o
);

  cl_word_t w;

  always_comb begin
    w       = '0;
    {w.blu, w.grn, w.red} = place_pixel(fmt_i, pix_i);
    w.lval  = lval_i;
    w.fval  = fval_i;
    w.dval  = dval_i;
    w.spare = 1'b0;
  end

  assign word_o = w;

endmodule

// File: rtl/clser_lane.sv
module clser_lane #(
  parameter int unsigned SLOTS = clser_pkg::CL_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);

  logic [SLOTS-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sreg_q <= '0;
    else if (load_i) sreg_q <= par_i;
    else             sreg_q <= {sreg_q[SLOTS-2:0], 1'b0};
  end

  assign ser_o = sreg_q[SLOTS-1];

endmodule

// File: rtl/clink_serializer.sv
module clink_serializer
  import clser_pkg::*;
#(
  parameter int unsigned SLOTS      = CL_SLOTS,
  parameter int unsigned LANES      = CL_LANES,
  parameter int unsigned HIGH_SLOTS = CL_HIGH,
  localparam int unsigned WORD_W    = SLOTS * LANES,
  localparam int unsigned PW        = $clog2(SLOTS)
) (
  input  logic                clk_bit,
  input  logic                rst_n,
  input  logic [1:0]          fmt_i,
  input  logic [CL_PIX_W-1:0] pix_i,
  input  logic                lval_i,
  input  logic                fval_i,
  input  logic                dval_i,
  output logic                take_o,
  output logic                clk_lane_o,
  output logic [LANES-1:0]    data_lane_o
);

  logic [PW-1:0]      slot;
  logic               load;
  logic [WORD_W-1:0]  mapped_word;

  clser_phase #(.SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS)) u_phase (
    .clk        (clk_bit),
    .rst_n      (rst_n),
    .slot_o     (slot),
    .load_o     (load),
    .clk_lane_o (clk_lane_o)
  );

  clser_mapper u_map (
    .fmt_i  (fmt_e'(fmt_i)),
    .pix_i  (pix_i),
    .lval_i (lval_i),
    .fval_i (fval_i),
    .dval_i (dval_i),
    .word_o (mapped_word)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    clser_lane #(.SLOTS(SLOTS)) u_lane (
      .clk    (clk_bit),
      .rst_n  (rst_n),
      .load_i (load),
      .par_i  (mapped_word[k*SLOTS +: SLOTS]),
      .ser_o  (data_lane_o[k])
    );
  end

  assign take_o = load;

  logic unused_slot;
  assign unused_slot = ^slot;

endmodule

// File: rtl/clser_checker.sv
module clser_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        take,
  input logic        clk_lane,
  input logic [3:0]  data_lane,
  input logic [27:0] word
);

  logic [2:0] since_take, hi_run, lo_run;
  logic       seen_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_take <= '0;
      hi_run     <= '0;
      lo_run     <= '0;
      seen_take  <= 1'b0;
    end else begin
      since_take <= take ? 3'd0 : (since_take == 3'd7 ? 3'd7 : since_take + 3'd1);
      seen_take  <= seen_take | take;
      hi_run     <= clk_lane ? (hi_run == 3'd7 ? 3'd7 : hi_run + 3'd1) : 3'd0;
      lo_run     <= clk_lane ? 3'd0 : (lo_run == 3'd7 ? 3'd7 : lo_run + 3'd1);
    end
  end

  // R2: consecutive captures are exactly seven cycles apart
  a_r2_take_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (take && seen_take) |-> since_take == 3'd6);

  // R2: capture never lasts two cycles and sits in the clock high phase
  a_r2_take_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> clk_lane && !$past(take));

  // R3: high run of four before each fall
  a_r3_high_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_lane) |-> hi_run == 3'd4);

  // R3: low run of three before each rise
  a_r3_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_lane) |-> lo_run == 3'd3);

  // R4: first slot after capture carries b6 of every lane
  a_r4_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) |-> data_lane == {$past(word[27]), $past(word[20]),
                                  $past(word[13]), $past(word[6])});

  // R10: spare bit leaves lane 3 as zero
  a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) |-> !data_lane[3]);

endmodule

bind clink_serializer clser_checker u_chk (
  .clk       (clk_bit),
  .rst_n     (rst_n),
  .take      (take_o),
  .clk_lane  (clk_lane_o),
  .data_lane (data_lane_o),
  .word      (mapped_word)
);

// File: tb/clink_serializer_test.sv
module clink_serializer_test;

  logic        clk_bit = 1'b0;
  logic        rst_n   = 1'b0;
  logic [1:0]  fmt_i   = 2'd0;
  logic [23:0] pix_i   = '0;
  logic        lval_i  = 1'b0;
  logic        fval_i  = 1'b0;
  logic        dval_i  = 1'b0;
  logic        take_o, clk_lane_o;
  logic [3:0]  data_lane_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk_bit = ~clk_bit;

  clink_serializer uut (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .fmt_i       (fmt_i),
    .pix_i       (pix_i),
    .lval_i      (lval_i),
    .fval_i      (fval_i),
    .dval_i      (dval_i),
    .take_o      (take_o),
    .clk_lane_o  (clk_lane_o),
    .data_lane_o (data_lane_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word, built from the format rules channel by channel.
  function automatic logic [27:0] expect_word(input logic [1:0] fmt, input logic [23:0] p,
                                             input logic l, input logic f, input logic d);
    logic [7:0] r, g, b;
    b = 8'h00;
    if (fmt == 2'd2) begin            // R8
      r = {p[1:0], 6'b000000};
      g = {2'b00, p[7:2]};
    end else begin
      r = p[7:0];                     // R6, R7, R9
      g = (fmt == 2'd1) ? (p[15:8] & 8'h3F) : p[15:8];
      if (fmt == 2'd0) b = p[23:16];
    end
    return {1'b0, d, f, l, b, g, r};  // R5, R10, R11
  endfunction

  // Called at a falling edge where take_o is high; sends one pixel and
  // collects its seven slots. Ends at the next falling edge with take_o high.
  task automatic send_pixel(input logic [1:0] fmt, input logic [23:0] p,
                            input logic l, input logic f, input logic d,
                            input string req);
    logic [27:0] exp, got;
    logic [6:0]  clk_seen;
    logic [6:0]  take_seen;
    fmt_i = fmt; pix_i = p; lval_i = l; fval_i = f; dval_i = d;
    exp = expect_word(fmt, p, l, f, d);
    got = '0;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk_bit);
      for (int k = 0; k < 4; k++) got[7*k + 6 - s] = data_lane_o[k];
      clk_seen[s]  = clk_lane_o;
      take_seen[s] = take_o;
    end
    chk(got == exp, {req, " R4 lane bits"}, 32'(got), 32'(exp));
    // R3: slots 0,1,5,6 high; 2,3,4 low (index = slot)
    chk(clk_seen == 7'b1100011, "R3 clock lane slots", 32'(clk_seen), 32'h63);
    chk(take_seen == 7'b1000000, "R2 take slot", 32'(take_seen), 32'h40);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic t_reset;
    repeat (4) @(negedge clk_bit);
    chk(data_lane_o == 4'h0, "R1 lanes in reset", 32'(data_lane_o), 32'h0);
    chk(clk_lane_o == 1'b1, "R1 clock lane in reset", 32'(clk_lane_o), 32'h1);
    chk(take_o == 1'b0, "R1 take in reset", 32'(take_o), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_sync;
    int guard = 0;
    do begin
      @(negedge clk_bit);
      guard++;
    end while (!take_o && guard < 20);
    chk(take_o == 1'b1 && guard <= 7, "R2 first take after reset", 32'(guard), 32'd2);
  endtask

  task automatic t_formats;
    send_pixel(2'd0, 24'hA53C96, 1, 1, 1, "R6 rgb");
    send_pixel(2'd1, 24'hC3E781, 1, 1, 1, "R7 gray14 R10");
    send_pixel(2'd2, 24'h7E55B6, 1, 0, 1, "R8 gray8 R10");
    send_pixel(2'd3, 24'hF0C35A, 0, 1, 1, "R9 wide16 R10");
  endtask

  task automatic t_ignored_bits;
    // R10: only bits outside each field change; lanes must match zero-field words
    send_pixel(2'd2, 24'hFFFF00, 1, 1, 1, "R10 gray8 upper ignored");
    send_pixel(2'd1, 24'hFFC000, 1, 1, 1, "R10 gray14 upper ignored");
    send_pixel(2'd3, 24'hFF0000, 0, 0, 0, "R10 wide16 blue ignored");
  endtask

  task automatic t_flags;
    send_pixel(2'd0, 24'hFFFFFF, 0, 0, 0, "R11 flags low");
    send_pixel(2'd0, 24'h000000, 1, 0, 0, "R11 lval only");
    send_pixel(2'd2, 24'h000000, 0, 1, 0, "R11 fval only");
    send_pixel(2'd1, 24'h000000, 0, 0, 1, "R11 dval only");
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < 8; i++)
      send_pixel(2'(i), 24'h135790 ^ (24'h0F1E2D * 24'(i)), 1'(i), 1'(i >> 1), 1,
                 "R12 back-to-back");
  endtask

  initial begin
    t_reset();
    t_sync();
    t_formats();
    t_ignored_bits();
    t_flags();
    t_back_to_back();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule